// File: doc/BRIEF.md
# Watchdog Timer with Keyed Control Access

This block is a machine-cycle watchdog for a microcontroller core. A prescaler divides the system clock into machine-cycle ticks, and a timeout counter counts those ticks. If software does not restart the counter before a fixed number of machine cycles has passed, and the reset-enable bit is set, the block drives a system reset pulse. It also sets a sticky status flag that start-up code can read to learn that the last reset came from the watchdog.

Software can change the reset-enable and restart bits only after it unlocks them. It writes two fixed key bytes, one after the other, to a key register. It must then write the control register within a short window. A write to the control register at any other time has no effect. This makes it very unlikely that runaway code disables or feeds the watchdog by accident.

Top module: `guard_timer`

## Requirements
- R1: With the reset-enable bit set, `wdt_rst` rises CLKS_PER_MCYCLE*TIMEOUT_MCYC clocks after the clock edge that last cleared the count. A restart clears the count, and so does the previous expiry. `wdt_flag` is 1 in the same cycle that `wdt_rst` rises.
- R2: Each reset pulse stays high for exactly RST_MCYC*CLKS_PER_MCYCLE clocks.
- R3: A granted restart (control write with bit 0 = 1) clears the count. A full new interval then starts at that edge. A restart in the same cycle as an expiry suppresses that expiry.
- R4: When the reset-enable bit is 0, an expiry produces no reset pulse. The count still wraps.
- R5: The unlock sequence has three steps, each a separate write. First write KEY_A (default 0xAA) to the key register (`wr_sel`=0). Then, as the very next write, write KEY_B (default 0x55) to the key register. Then write the control register (`wr_sel`=1). Bit 2 of that write sets the reset-enable bit, and bit 0 = 1 requests a restart.
- R6: A control write that does not come right after a valid key pair is ignored, and the enable bit keeps its value. This includes a wrong second key and any other register write between the two keys.
- R7: The control write must come within WINDOW_MCYC*CLKS_PER_MCYCLE clocks after the second key write. A write at exactly that delay is accepted. A write one clock later is ignored.
- R8: `ctrl_rdata` shows the reset-enable bit at bit 2. The restart bit clears itself and always reads 0. All other bits read 0.
- R9: `wdt_flag` stays set once set. Only `por_n` clears it, and the reset pulse it records does not clear it.
- R10: After `por_n` is asserted, `wdt_rst`, `wdt_flag` and `ctrl_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_sel | input | 1 | Write target: 0 = key register, 1 = control register |
| wr_data | input | DATA_W | Write data |
| ctrl_rdata | output | DATA_W | Control register readback (bit 2 = reset enable) |
| wdt_rst | output | 1 | System reset request pulse |
| wdt_flag | output | 1 | Sticky flag: a watchdog reset has occurred |

## Verification
A control write is taken at the clock edge that samples it, so the enable readback changes one clock after the write cycle. The count starts from zero at that same edge. The reset pulse and the flag appear exactly CLKS_PER_MCYCLE*TIMEOUT_MCYC clocks after it. The bench runs a behavioural model that counts elapsed clocks. It compares the model with all three outputs half a clock after every edge, so any result that comes one cycle early or late is caught. Directed checks count the clocks from a restart to the rising edge of the reset pulse. They also measure the pulse width and probe the unlock window at its last accepted clock and at the first clock after it.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;
   typedef enum logic [1:0] {
      TA_IDLE = 2'd0,
      TA_HALF = 2'd1,
      TA_OPEN = 2'd2
   } ta_state_e;

   localparam int unsigned EN_BIT  = 2;
   localparam int unsigned RST_BIT = 0;
endpackage

// File: rtl/guard_timer_prescale.sv
module guard_timer_prescale #(
   parameter int unsigned DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (clr || pre_q == LAST) begin
               pre_q <= '0;
            end else begin
               pre_q <= pre_q + 1'b1;
            end
         end

         assign tick = (pre_q == LAST) && !clr;
      end
   endgenerate
endmodule

// File: rtl/guard_timer_unlock.sv
module guard_timer_unlock
   import guard_timer_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter logic [DATA_W-1:0] KEY_A = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_B = 8'h55,
   parameter int unsigned WIN_CLKS = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output ta_state_e         state
);
   localparam int unsigned WW = $clog2(WIN_CLKS + 1);
   localparam logic [WW-1:0] WLOAD = WW'(WIN_CLKS - 1);

   ta_state_e     st_q, st_d;
   logic [WW-1:0] win_q, win_d;

   always_comb begin
      st_d  = st_q;
      win_d = win_q;
      unique case (st_q)
         TA_IDLE: begin
            if (wr_en && !wr_sel && wr_data == KEY_A) begin
               st_d  = TA_HALF;
               win_d = WLOAD;
            end
         end
         TA_HALF: begin
            if (wr_en) begin
               if (!wr_sel && wr_data == KEY_B) begin
                  st_d  = TA_OPEN;
                  win_d = WLOAD;
               end else begin
                  st_d = TA_IDLE;
               end
            end else if (win_q == '0) begin
               st_d = TA_IDLE;
            end else begin
               win_d = win_q - 1'b1;
            end
         end
         TA_OPEN: begin
            if (wr_en || win_q == '0) begin
               st_d = TA_IDLE;
            end else begin
               win_d = win_q - 1'b1;
            end
         end
         default: st_d = TA_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= TA_IDLE;
         win_q <= '0;
      end else begin
         st_q  <= st_d;
         win_q <= win_d;
      end
   end

   assign state = st_q;
endmodule

// File: rtl/guard_timer_interval.sv
module guard_timer_interval #(
   parameter int unsigned TIMEOUT_MCYC = 122800,
   parameter int unsigned PULSE_CLKS   = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   input  logic arm,
   output logic expire,
   output logic rst_out
);
   localparam int unsigned CW = $clog2(TIMEOUT_MCYC);
   localparam int unsigned PW = $clog2(PULSE_CLKS + 1);
   localparam logic [CW-1:0] CLAST = CW'(TIMEOUT_MCYC - 1);
   localparam logic [PW-1:0] PLOAD = PW'(PULSE_CLKS);

   logic [CW-1:0] cnt_q;
   logic [PW-1:0] pul_q;

   assign expire = tick && (cnt_q == CLAST) && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || expire) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pul_q <= '0;
      end else if (expire && arm) begin
         pul_q <= PLOAD;
      end else if (pul_q != '0) begin
         pul_q <= pul_q - 1'b1;
      end
   end

   assign rst_out = (pul_q != '0);
endmodule

// File: rtl/guard_timer.sv
module guard_timer
   import guard_timer_pkg::*;
#(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned CLKS_PER_MCYCLE = 12,
   parameter int unsigned TIMEOUT_MCYC    = 122800,
   parameter int unsigned WINDOW_MCYC     = 4,
   parameter int unsigned RST_MCYC        = 2,
   parameter logic [DATA_W-1:0] KEY_A     = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_B     = 8'h55
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] ctrl_rdata,
   output logic              wdt_rst,
   output logic              wdt_flag
);
   localparam int unsigned WIN_CLKS   = WINDOW_MCYC * CLKS_PER_MCYCLE;
   localparam int unsigned PULSE_CLKS = RST_MCYC * CLKS_PER_MCYCLE;

   generate
      if (DATA_W <= EN_BIT) begin : g_bad_width
         $error("guard_timer: DATA_W too narrow for control bits");
      end
      if (CLKS_PER_MCYCLE < 1 || TIMEOUT_MCYC < 2) begin : g_bad_timing
         $error("guard_timer: prescale and timeout must be positive");
      end
      if (RST_MCYC < 1 || RST_MCYC >= TIMEOUT_MCYC) begin : g_bad_pulse
         $error("guard_timer: reset pulse must be shorter than the timeout");
      end
      if (WINDOW_MCYC < 1) begin : g_bad_window
         $error("guard_timer: unlock window must be at least one cycle");
      end
      if (KEY_A == KEY_B) begin : g_bad_keys
         $error("guard_timer: the two keys must differ");
      end
   endgenerate

   ta_state_e ta_state;
   logic      grant, restart, tick, expire, en_q, flag_q;

   guard_timer_unlock #(
      .DATA_W  (DATA_W),
      .KEY_A   (KEY_A),
      .KEY_B   (KEY_B),
      .WIN_CLKS(WIN_CLKS)
   ) u_unlock (
      .clk    (clk),
      .rst_n  (por_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .state  (ta_state)
   );

   assign grant   = wr_en && wr_sel && (ta_state == TA_OPEN);
   assign restart = grant && wr_data[RST_BIT];

   guard_timer_prescale #(
      .DIV(CLKS_PER_MCYCLE)
   ) u_pre (
      .clk  (clk),
      .rst_n(por_n),
      .clr  (restart),
      .tick (tick)
   );

   guard_timer_interval #(
      .TIMEOUT_MCYC(TIMEOUT_MCYC),
      .PULSE_CLKS  (PULSE_CLKS)
   ) u_ivl (
      .clk    (clk),
      .rst_n  (por_n),
      .tick   (tick),
      .restart(restart),
      .arm    (en_q),
      .expire (expire),
      .rst_out(wdt_rst)
   );

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         en_q <= 1'b0;
      end else if (grant) begin
         en_q <= wr_data[EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         flag_q <= 1'b0;
      end else if (expire && en_q) begin
         flag_q <= 1'b1;
      end
   end

   always_comb begin
      ctrl_rdata         = '0;
      ctrl_rdata[EN_BIT] = en_q;
   end

   assign wdt_flag = flag_q;
endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk
   import guard_timer_pkg::*;
#(
   parameter int unsigned DATA_W          = 8,
   parameter int unsigned CLKS_PER_MCYCLE = 12,
   parameter int unsigned WINDOW_MCYC     = 4,
   parameter int unsigned RST_MCYC        = 2
) (
   input logic              clk,
   input logic              por_n,
   input logic              wr_en,
   input logic              wr_sel,
   input logic [DATA_W-1:0] ctrl_rdata,
   input logic              wdt_rst,
   input logic              wdt_flag,
   input ta_state_e         ta_state
);
   localparam int unsigned PULSE = RST_MCYC * CLKS_PER_MCYCLE;
   localparam int unsigned WIN   = WINDOW_MCYC * CLKS_PER_MCYCLE;

   int unsigned hi_len, open_len;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         hi_len   <= 0;
         open_len <= 0;
      end else begin
         hi_len   <= wdt_rst ? hi_len + 1 : 0;
         open_len <= (ta_state == TA_OPEN) ? open_len + 1 : 0;
      end
   end

   p_pulse_short_r2: assert property (@(posedge clk) disable iff (!por_n)
      wdt_rst |-> hi_len < PULSE);

   p_pulse_full_r2: assert property (@(posedge clk) disable iff (!por_n)
      $fell(wdt_rst) |-> hi_len == PULSE);

   p_flag_with_rst_r1: assert property (@(posedge clk) disable iff (!por_n)
      $rose(wdt_rst) |-> wdt_flag);

   p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
      wdt_flag |=> wdt_flag);

   p_armed_only_r4: assert property (@(posedge clk) disable iff (!por_n)
      $rose(wdt_rst) |-> $past(ctrl_rdata[EN_BIT]));

   p_locked_ctrl_r6: assert property (@(posedge clk) disable iff (!por_n)
      (wr_en && wr_sel && ta_state != TA_OPEN) |=> $stable(ctrl_rdata));

   p_window_r7: assert property (@(posedge clk) disable iff (!por_n)
      (ta_state == TA_OPEN) |-> open_len < WIN);
endmodule

bind guard_timer guard_timer_chk #(
   .DATA_W         (DATA_W),
   .CLKS_PER_MCYCLE(CLKS_PER_MCYCLE),
   .WINDOW_MCYC    (WINDOW_MCYC),
   .RST_MCYC       (RST_MCYC)
) u_chk (.*);

// File: tb/sim_guard_timer.sv
`timescale 1ns/1ps
module sim_guard_timer;
   localparam int P = 3, T = 20, W = 2, R = 2;
   localparam int IVL = P * T, PUL = R * P, WIN = W * P;

   logic       clk = 1'b0, por_n = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00, ctrl_rdata;
   logic       wdt_rst, wdt_flag;
   int         checks = 0, fails = 0, cyc = 0;

   always #2.5 clk = ~clk;

   guard_timer #(.DATA_W(8), .CLKS_PER_MCYCLE(P), .TIMEOUT_MCYC(T),
                 .WINDOW_MCYC(W), .RST_MCYC(R)) u0 (
      .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .ctrl_rdata(ctrl_rdata), .wdt_rst(wdt_rst),
      .wdt_flag(wdt_flag));

   // behavioural reference: clocks elapsed since last clear, key age counter
   int m_elapsed, m_state, m_age, m_pulse;
   bit m_en, m_flag;

   always @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         m_elapsed <= 0; m_state <= 0; m_age <= 0; m_pulse <= 0;
         m_en <= 0; m_flag <= 0;
      end else begin
         bit g, rs, ex;
         g  = wr_en && wr_sel && m_state == 2;
         rs = g && wr_data[0];
         ex = !rs && m_elapsed == IVL - 1;
         if (ex && m_en) begin m_pulse <= PUL; m_flag <= 1; end
         else if (m_pulse > 0) m_pulse <= m_pulse - 1;
         m_elapsed <= (rs || ex) ? 0 : m_elapsed + 1;
         if (g) m_en <= wr_data[2];
         if (m_state == 0) begin
            if (wr_en && !wr_sel && wr_data == 8'hAA) begin m_state <= 1; m_age <= 0; end
         end else if (wr_en) begin
            if (m_state == 1 && !wr_sel && wr_data == 8'h55) begin m_state <= 2; m_age <= 0; end
            else m_state <= 0;
         end else if (m_age == WIN - 1) m_state <= 0;
         else m_age <= m_age + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always @(negedge clk) if (por_n) begin
      chk(wdt_rst == (m_pulse > 0), "R1/R2 model rst", wdt_rst, m_pulse > 0);
      chk(wdt_flag == m_flag, "R9 model flag", wdt_flag, m_flag);
      chk(ctrl_rdata == {5'b0, m_en, 2'b0}, "R8 model rdata", ctrl_rdata, {5'b0, m_en, 2'b0});
   end

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         chk(0, "watchdog", cyc, 0);
         finish_run();
      end
   end

   // inputs change 1 ns after an edge; the write is sampled at the next edge
   task automatic wr(input bit sel, input logic [7:0] d);
      wr_en = 1; wr_sel = sel; wr_data = d;
      @(posedge clk); #1;
      wr_en = 0; wr_data = 8'h00;
   endtask

   task automatic idle(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   task automatic unlock_and(input logic [7:0] d);
      wr(0, 8'hAA); wr(0, 8'h55); wr(1, d);
   endtask

   task automatic clocks_to_rst(output int n);
      n = 0;
      while (!wdt_rst && n < 500) begin @(posedge clk); #1; n++; end
   endtask

   initial begin
      int n;
      idle(2);
      chk(ctrl_rdata == 0, "R10 rdata", ctrl_rdata, 0);
      chk(!wdt_rst && !wdt_flag, "R10 rst/flag", {wdt_rst, wdt_flag}, 0);
      por_n = 1; idle(1);

      wr(1, 8'h04);
      chk(ctrl_rdata == 0, "R6 locked write", ctrl_rdata, 0);

      unlock_and(8'h05);
      chk(ctrl_rdata == 8'h04, "R5/R8 enable set, restart reads 0", ctrl_rdata, 4);
      clocks_to_rst(n);
      chk(n == IVL, "R1/R3 interval", n, IVL);
      chk(wdt_flag, "R1 flag with rst", wdt_flag, 1);
      n = 0;
      while (wdt_rst && n < 100) begin @(posedge clk); #1; n++; end
      chk(n == PUL, "R2 pulse width", n, PUL);
      chk(wdt_flag, "R9 flag survives pulse", wdt_flag, 1);

      wr(0, 8'hAA); wr(0, 8'h56); wr(1, 8'h00);
      chk(ctrl_rdata == 8'h04, "R6 wrong key", ctrl_rdata, 4);
      wr(0, 8'hAA); wr(1, 8'h00); wr(0, 8'h55); wr(1, 8'h00);
      chk(ctrl_rdata == 8'h04, "R6 intervening write", ctrl_rdata, 4);

      wr(0, 8'hAA); wr(0, 8'h55); idle(WIN); wr(1, 8'h00);
      chk(ctrl_rdata == 8'h04, "R7 late write rejected", ctrl_rdata, 4);
      wr(0, 8'hAA); wr(0, 8'h55); idle(WIN - 1); wr(1, 8'h01);
      chk(ctrl_rdata == 8'h00, "R7 last-clock write accepted", ctrl_rdata, 0);

      clocks_to_rst(n);
      chk(n == 500, "R4 no rst when disabled", n, 500);
      chk(wdt_flag, "R9 flag still set", wdt_flag, 1);

      unlock_and(8'h05); idle(40); unlock_and(8'h05);
      clocks_to_rst(n);
      chk(n == IVL, "R3 restart mid-interval", n, IVL);
      idle(PUL + 2);

      por_n = 0; #1;
      chk(!wdt_flag && ctrl_rdata == 0, "R9/R10 por clears", {wdt_flag, ctrl_rdata}, 0);
      idle(1); por_n = 1; idle(3);
      finish_run();
   end
endmodule